// File: doc/BRIEF.md
# Atomic Fetch-and-Op Memory Unit

This unit performs one indivisible read-modify-write on a single memory location for an atomic load instruction that has already been decoded. A request brings a byte address, a 5-bit function code (taken from instruction bits 15..11), an operand value, a width select (32-bit word or 64-bit doubleword) and the tag of the destination register. The unit reads the old value and combines it with the operand. It writes the result back while it holds the memory lock, then returns the old value so the core can write it to the destination register.

The operand is the contents of the register whose number is one above the destination. The unit presents that source number so the register file can supply the value. Requests that cannot run end without touching memory. These are a misaligned address, a function code that is reserved for operations not built here, and any other unknown code. Each such request ends with a fault status and no register write.

Top module: `amo_unit`

## Requirements
- R1: `req_ready` is high only while the unit is idle. A `req_valid` presented while the unit is busy is ignored: it produces no done pulse and no memory access.
- R2: For an accepted, aligned request, function code 0 stores old+operand, 1 stores old XOR operand, 2 stores old OR operand, 3 stores old AND operand, and 8 stores the operand (swap). In every case `done_data` returns the value memory held before the operation.
- R3: Addition wraps modulo 2^32 in word mode and 2^64 in doubleword mode. No carry leaves the accessed bytes.
- R4: Function codes 4, 5, 6, 7, 16, 24, 25 and 28 end with status 2 (illegal instruction) and make no memory access.
- R5: Every function code not named in R2 or R4 ends with status 3 (storage exception, invalid form) and makes no memory access.
- R6: Word mode needs address bits [1:0] equal to 0, and doubleword mode needs bits [2:0] equal to 0. A misaligned request ends with status 1 whatever its function code and makes no memory access.
- R7: In word mode (`req_dword`=0) only operand bits [31:0] are used. The old value is `mem_rdata[31:0]` zero-extended to 64 bits, and only 4 bytes are written. Doubleword mode uses all 64 bits.
- R8: A successful request makes exactly one read (`mem_we`=0) and, in the very next cycle, one write to the same address, with `mem_lock` high in both cycles. The memory returns read data one cycle after the read request. `done` rises in the third cycle after acceptance.
- R9: `done` is a one-cycle pulse that carries the request's tag on `done_rt`. `done_wen` is high only when the status is 0. A faulting request raises `done` in the cycle after acceptance.
- R10: `src_rt` equals `req_rt`+1, wrapping from 31 to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Unit idle and accepting |
| req_addr | input | AW | Byte address |
| req_fc | input | 5 | Function code |
| req_operand | input | 64 | Operand value (register src_rt) |
| req_dword | input | 1 | 1 = doubleword, 0 = word |
| req_rt | input | TW | Destination register tag |
| src_rt | output | TW | Operand source register number |
| mem_req | output | 1 | Memory access this cycle |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_lock | output | 1 | Memory held for this unit |
| mem_dword | output | 1 | Access width select |
| mem_addr | output | AW | Access byte address |
| mem_wdata | output | 64 | Write data |
| mem_rdata | input | 64 | Read data, valid one cycle after a read |
| done | output | 1 | Completion pulse |
| done_rt | output | TW | Tag of the finished request |
| done_wen | output | 1 | Write done_data to done_rt |
| done_data | output | 64 | Old memory value |
| done_status | output | 2 | 0 ok, 1 misaligned, 2 illegal, 3 storage exception |

## Verification
A wrong decode or a stale latched request shows at the ports within three cycles, as a wrong status, a wrong returned value or a changed byte in memory. A broken sequencer shows in the same operation as a missing or extra memory access, a dropped lock, or a done pulse in the wrong cycle. A fault path that reaches memory changes the access count or the memory image before the next request starts. Word-width errors appear as junk in the upper 32 bits of the returned value, or as a changed byte next to the accessed word.

// File: rtl/amo_pkg.sv
`timescale 1ns/1ps
package amo_pkg;

    typedef enum logic [1:0] {
        ST_OK       = 2'd0,
        ST_MISALIGN = 2'd1,
        ST_ILLEGAL  = 2'd2,
        ST_STORAGE  = 2'd3
    } amo_status_e;

    typedef enum logic [2:0] {
        OP_ADD,
        OP_XOR,
        OP_OR,
        OP_AND,
        OP_SWAP,
        OP_NONE
    } amo_op_e;

    typedef struct packed {
        amo_op_e     op;
        amo_status_e fault;
    } amo_dec_t;

    typedef enum logic [1:0] {
        S_IDLE,
        S_READ,
        S_WRITE,
        S_RESP
    } amo_state_e;

    function automatic amo_dec_t decode_code(input logic [4:0] code);
        amo_dec_t d;
        d.op    = OP_NONE;
        d.fault = ST_OK;
        case (code)
            5'd0:  d.op = OP_ADD;
            5'd1:  d.op = OP_XOR;
            5'd2:  d.op = OP_OR;
            5'd3:  d.op = OP_AND;
            5'd8:  d.op = OP_SWAP;
            5'd4, 5'd5, 5'd6, 5'd7,
            5'd16, 5'd24, 5'd25, 5'd28: d.fault = ST_ILLEGAL;
            default: d.fault = ST_STORAGE;
        endcase
        return d;
    endfunction

    function automatic logic is_misaligned(input logic [2:0] lsb, input logic dword);
        return dword ? (lsb != 3'd0) : (lsb[1:0] != 2'd0);
    endfunction

endpackage

// File: rtl/amo_decode.sv
`timescale 1ns/1ps
module amo_decode
    import amo_pkg::*;
(
    input  logic [4:0] code,
    input  logic [2:0] addr_lsb,
    input  logic       dword,
    output amo_dec_t   dec
);
    amo_dec_t raw;

    always_comb begin
        raw = decode_code(code);
        dec = raw;
        // alignment is checked ahead of the function code
        if (is_misaligned(addr_lsb, dword)) begin
            dec.op    = OP_NONE;
            dec.fault = ST_MISALIGN;
        end
    end
endmodule

// File: rtl/amo_alu.sv
`timescale 1ns/1ps
module amo_alu
    import amo_pkg::*;
#(
    parameter int DW = 64
) (
    input  amo_op_e         op,
    input  logic            dword,
    input  logic [DW-1:0]   mem_old,
    input  logic [DW-1:0]   operand,
    output logic [DW-1:0]   old_ext,
    output logic [DW-1:0]   new_val
);
    localparam int WW = DW / 2;

    logic [DW-1:0] a, b, r;

    always_comb begin
        a = dword ? mem_old : {{WW{1'b0}}, mem_old[WW-1:0]};
        b = dword ? operand : {{WW{1'b0}}, operand[WW-1:0]};
        case (op)
            OP_ADD:  r = a + b;
            OP_XOR:  r = a ^ b;
            OP_OR:   r = a | b;
            OP_AND:  r = a & b;
            OP_SWAP: r = b;
            default: r = a;
        endcase
        old_ext = a;
        new_val = dword ? r : {{WW{1'b0}}, r[WW-1:0]};
    end
endmodule

// File: rtl/amo_ctrl.sv
`timescale 1ns/1ps
module amo_ctrl
    import amo_pkg::*;
#(
    parameter int AW = 16,
    parameter int DW = 64,
    parameter int TW = 5
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          req_valid,
    input  logic [AW-1:0] req_addr,
    input  logic [DW-1:0] req_operand,
    input  logic          req_dword,
    input  logic [TW-1:0] req_rt,
    input  amo_dec_t      req_dec,
    output logic          req_ready,
    output logic          mem_req,
    output logic          mem_we,
    output logic          mem_lock,
    output logic          mem_dword,
    output logic [AW-1:0] mem_addr,
    output amo_op_e       cur_op,
    output logic [DW-1:0] cur_operand,
    input  logic [DW-1:0] alu_old,
    output logic          done,
    output logic [TW-1:0] done_rt,
    output logic          done_wen,
    output logic [DW-1:0] done_data,
    output amo_status_e   done_status
);
    amo_state_e    state;
    logic [AW-1:0] addr_q;
    logic [DW-1:0] opnd_q;
    logic [DW-1:0] data_q;
    logic [TW-1:0] rt_q;
    logic          dword_q;
    amo_op_e       op_q;
    amo_status_e   status_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= S_IDLE;
            addr_q   <= '0;
            opnd_q   <= '0;
            data_q   <= '0;
            rt_q     <= '0;
            dword_q  <= 1'b0;
            op_q     <= OP_NONE;
            status_q <= ST_OK;
        end else begin
            case (state)
                S_IDLE: if (req_valid) begin
                    addr_q   <= req_addr;
                    opnd_q   <= req_operand;
                    dword_q  <= req_dword;
                    rt_q     <= req_rt;
                    op_q     <= req_dec.op;
                    status_q <= req_dec.fault;
                    data_q   <= '0;
                    state    <= (req_dec.fault == ST_OK) ? S_READ : S_RESP;
                end
                S_READ:  state <= S_WRITE;
                S_WRITE: begin
                    data_q <= alu_old;
                    state  <= S_RESP;
                end
                default: state <= S_IDLE;
            endcase
        end
    end

    always_comb begin
        req_ready   = (state == S_IDLE);
        mem_req     = (state == S_READ) || (state == S_WRITE);
        mem_we      = (state == S_WRITE);
        mem_lock    = mem_req;
        mem_dword   = dword_q;
        mem_addr    = addr_q;
        cur_op      = op_q;
        cur_operand = opnd_q;
        done        = (state == S_RESP);
        done_rt     = rt_q;
        done_wen    = done && (status_q == ST_OK);
        done_data   = data_q;
        done_status = status_q;
    end
endmodule

// File: rtl/amo_unit.sv
`timescale 1ns/1ps
module amo_unit
    import amo_pkg::*;
#(
    parameter int AW = 16,
    parameter int TW = 5
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          req_valid,
    output logic          req_ready,
    input  logic [AW-1:0] req_addr,
    input  logic [4:0]    req_fc,
    input  logic [63:0]   req_operand,
    input  logic          req_dword,
    input  logic [TW-1:0] req_rt,
    output logic [TW-1:0] src_rt,
    output logic          mem_req,
    output logic          mem_we,
    output logic          mem_lock,
    output logic          mem_dword,
    output logic [AW-1:0] mem_addr,
    output logic [63:0]   mem_wdata,
    input  logic [63:0]   mem_rdata,
    output logic          done,
    output logic [TW-1:0] done_rt,
    output logic          done_wen,
    output logic [63:0]   done_data,
    output logic [1:0]    done_status
);
    localparam int DW = 64;

    amo_dec_t      dec;
    amo_op_e       cur_op;
    logic [DW-1:0] cur_operand;
    logic [DW-1:0] alu_old;
    amo_status_e   status_e;

    assign src_rt      = req_rt + TW'(1);
    assign done_status = status_e;

    amo_decode u_dec (
        .code     (req_fc),
        .addr_lsb (req_addr[2:0]),
        .dword    (req_dword),
        .dec      (dec)
    );

    amo_ctrl #(.AW(AW), .DW(DW), .TW(TW)) u_ctrl (
        .clk         (clk),
        .rst         (rst),
        .req_valid   (req_valid),
        .req_addr    (req_addr),
        .req_operand (req_operand),
        .req_dword   (req_dword),
        .req_rt      (req_rt),
        .req_dec     (dec),
        .req_ready   (req_ready),
        .mem_req     (mem_req),
        .mem_we      (mem_we),
        .mem_lock    (mem_lock),
        .mem_dword   (mem_dword),
        .mem_addr    (mem_addr),
        .cur_op      (cur_op),
        .cur_operand (cur_operand),
        .alu_old     (alu_old),
        .done        (done),
        .done_rt     (done_rt),
        .done_wen    (done_wen),
        .done_data   (done_data),
        .done_status (status_e)
    );

    amo_alu #(.DW(DW)) u_alu (
        .op      (cur_op),
        .dword   (mem_dword),
        .mem_old (mem_rdata),
        .operand (cur_operand),
        .old_ext (alu_old),
        .new_val (mem_wdata)
    );
endmodule

// File: rtl/amo_unit_chk.sv
`timescale 1ns/1ps
module amo_unit_chk #(
    parameter int AW = 16
) (
    input logic          clk,
    input logic          rst,
    input logic          req_valid,
    input logic          req_ready,
    input logic [AW-1:0] req_addr,
    input logic          req_dword,
    input logic          mem_req,
    input logic          mem_we,
    input logic          mem_lock,
    input logic          done,
    input logic          done_wen,
    input logic [1:0]    done_status
);
    logic bad_align;
    assign bad_align = req_dword ? (req_addr[2:0] != 3'd0) : (req_addr[1:0] != 2'd0);

    // R8
    lock_with_req_chk: assert property (@(posedge clk) disable iff (rst)
        mem_req |-> mem_lock);

    // R8
    read_then_write_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_we) |=> (mem_req && mem_we));

    // R8
    write_after_read_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_req && mem_we) |-> $past(mem_req && !mem_we));

    // R9
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R9
    fault_no_wen_chk: assert property (@(posedge clk) disable iff (rst)
        (done && done_status != 2'd0) |-> !done_wen);

    // R1
    busy_not_ready_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_req || done) |-> !req_ready);

    // R6
    misalign_fault_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready && bad_align) |=> (done && done_status == 2'd1 && !mem_req));

    // R4
    illegal_no_mem_chk: assert property (@(posedge clk) disable iff (rst)
        (done && done_status == 2'd2) |-> !$past(mem_req));
endmodule

bind amo_unit amo_unit_chk #(.AW(AW)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .req_valid   (req_valid),
    .req_ready   (req_ready),
    .req_addr    (req_addr),
    .req_dword   (req_dword),
    .mem_req     (mem_req),
    .mem_we      (mem_we),
    .mem_lock    (mem_lock),
    .done        (done),
    .done_wen    (done_wen),
    .done_status (done_status)
);

// File: tb/amo_unit_tb.sv
`timescale 1ns/1ps
module amo_unit_tb;
    localparam int AW = 6;
    localparam int TW = 5;
    localparam int NB = 1 << AW;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic [AW-1:0] req_addr = '0;
    logic [4:0]    req_fc = '0;
    logic [63:0]   req_operand = '0;
    logic          req_dword = 1'b0;
    logic [TW-1:0] req_rt = '0;
    logic [TW-1:0] src_rt;
    logic          mem_req, mem_we, mem_lock, mem_dword;
    logic [AW-1:0] mem_addr;
    logic [63:0]   mem_wdata;
    logic [63:0]   mem_rdata = '0;
    logic          done, done_wen;
    logic [TW-1:0] done_rt;
    logic [63:0]   done_data;
    logic [1:0]    done_status;

    int total = 0;
    int bad = 0;
    int n_rd = 0, n_wr = 0, lock_bad = 0, order_bad = 0;
    logic last_rd = 1'b0;
    logic [AW-1:0] rd_addr = '0;

    logic [7:0] mem [NB];
    logic [7:0] ref_mem [NB];

    always #4 clk = ~clk;

    amo_unit #(.AW(AW), .TW(TW)) u_dut (.*);

    // memory model: read data one cycle after a read, junk in upper half for words
    always @(posedge clk) begin
        logic [63:0] rd;
        if (mem_req) begin
            if (!mem_lock) lock_bad++;
            if (mem_we) begin
                n_wr++;
                if (!last_rd || rd_addr != mem_addr) order_bad++;
                for (int i = 0; i < (mem_dword ? 8 : 4); i++)
                    mem[AW'(mem_addr + AW'(i))] <= mem_wdata[8*i +: 8];
            end else begin
                n_rd++;
                rd = mem_dword ? 64'd0 : 64'hA5C3_5A3C_0000_0000;
                for (int i = 0; i < (mem_dword ? 8 : 4); i++)
                    rd[8*i +: 8] = mem[AW'(mem_addr + AW'(i))];
                mem_rdata <= rd;
                rd_addr = mem_addr;
            end
        end
        last_rd = mem_req && !mem_we;
    end

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [1:0] exp_class(input logic [4:0] fc, input logic [AW-1:0] a, input logic dw);
        if (dw ? (a[2:0] != 0) : (a[1:0] != 0)) return 2'd1;
        case (fc)
            0, 1, 2, 3, 8: return 2'd0;
            4, 5, 6, 7, 16, 24, 25, 28: return 2'd2;
            default: return 2'd3;
        endcase
    endfunction

    task automatic run_op(input logic [AW-1:0] a, input logic [4:0] fc, input logic [63:0] opnd,
                          input logic dw, input logic [TW-1:0] rt, input bit inject, input string tag);
        logic [63:0] old_v, b, nv, m;
        logic [1:0]  cls;
        int lat;
        bit mem_ok;
        int nbytes;
        nbytes = dw ? 8 : 4;
        m = dw ? 64'hFFFF_FFFF_FFFF_FFFF : 64'h0000_0000_FFFF_FFFF;
        cls = exp_class(fc, a, dw);
        old_v = '0;
        if (cls == 2'd0)
            for (int i = 0; i < nbytes; i++) old_v[8*i +: 8] = ref_mem[AW'(a + AW'(i))];
        b = opnd & m;
        case (fc)
            0: nv = (old_v + b) & m;
            1: nv = old_v ^ b;
            2: nv = old_v | b;
            3: nv = old_v & b;
            default: nv = b;
        endcase
        n_rd = 0; n_wr = 0; lock_bad = 0; order_bad = 0;
        req_addr = a; req_fc = fc; req_operand = opnd; req_dword = dw; req_rt = rt;
        req_valid = 1'b1;
        @(negedge clk);
        lat = 1;
        req_valid = 1'b0;
        if (inject) begin
            req_valid = 1'b1; req_addr = AW'(56); req_fc = 5'd8; req_dword = 1'b1;
            req_operand = 64'hBAD0_BAD0_BAD0_BAD0; req_rt = rt + TW'(3);
        end
        while (!done && lat < 10) begin
            @(negedge clk);
            lat++;
            req_valid = 1'b0;
        end
        if (cls == 2'd0) for (int i = 0; i < nbytes; i++) ref_mem[AW'(a + AW'(i))] = nv[8*i +: 8];
        check(done, {tag, " R9 done"}, 64'(done), 64'd1);
        check(done_status == cls, {tag, (cls == 1) ? " R6" : (cls == 2) ? " R4" : (cls == 3) ? " R5" : " R2", " status"},
              64'(done_status), 64'(cls));
        check(done_rt == rt, {tag, " R9 tag"}, 64'(done_rt), 64'(rt));
        check(done_wen == (cls == 2'd0), {tag, " R9 wen"}, 64'(done_wen), 64'(cls == 2'd0));
        check(lat == ((cls == 2'd0) ? 3 : 1), {tag, " R8 latency"}, 64'(lat), (cls == 2'd0) ? 64'd3 : 64'd1);
        if (cls == 2'd0) begin
            check(done_data === old_v, {tag, dw ? " R2 old value" : " R7 old value"}, done_data, old_v);
            check(n_rd == 1 && n_wr == 1 && order_bad == 0 && lock_bad == 0, {tag, " R8 access"},
                  64'(n_rd * 16 + n_wr), 64'h11);
        end else begin
            check(n_rd == 0 && n_wr == 0, {tag, " R4 R5 R6 no access"}, 64'(n_rd + n_wr), 64'd0);
        end
        mem_ok = 1'b1;
        for (int i = 0; i < NB; i++) if (mem[i] !== ref_mem[i]) mem_ok = 1'b0;
        check(mem_ok, {tag, " R2 R3 R7 memory image"}, 64'(mem_ok), 64'd1);
        @(negedge clk);
        check(!done && req_ready, {tag, " R9 pulse"}, 64'(done), 64'd0);
        if (inject) begin
            repeat (4) begin
                @(negedge clk);
                check(!done && !mem_req, {tag, " R1 ignored while busy"}, 64'(done), 64'd0);
            end
        end
    endtask

    task automatic fill_mem(input logic [7:0] seed);
        for (int i = 0; i < NB; i++) begin
            mem[i] = 8'(seed + 8'(i * 37));
            ref_mem[i] = mem[i];
        end
    endtask

    task automatic put_dw(input logic [AW-1:0] a, input logic [63:0] v);
        for (int i = 0; i < 8; i++) begin
            mem[AW'(a + AW'(i))] = v[8*i +: 8];
            ref_mem[AW'(a + AW'(i))] = v[8*i +: 8];
        end
    endtask

    initial begin
        #(8 * 200000);
        bad++;
        total++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [63:0] pats [3];
        pats[0] = 64'hFFFF_FFFF_FFFF_FFFF;
        pats[1] = 64'h1234_5678_9ABC_DEF0;
        pats[2] = 64'h8000_0001_8000_0001;
        fill_mem(8'h11);
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(req_ready && !done && !mem_req && !done_wen, "reset R1 R9 idle", 64'(req_ready), 64'd1);

        // R10 source register number
        for (int t = 0; t < 32; t++) begin
            req_rt = TW'(t);
            #1;
            check(src_rt == TW'(t + 1), "R10 source tag", 64'(src_rt), 64'((t + 1) % 32));
        end

        // sweep every function code, both widths, several operands
        for (int dw = 0; dw < 2; dw++)
            for (int fc = 0; fc < 32; fc++)
                for (int p = 0; p < 3; p++)
                    run_op(AW'((fc * 8 + p * 16) % 56), 5'(fc), pats[p], dw[0], TW'(fc + p), 1'b0, "sweep");

        // misaligned offsets with good, illegal and unknown codes
        for (int dw = 0; dw < 2; dw++)
            for (int off = 1; off < 8; off++)
                if (dw == 1 || off < 4) begin
                    run_op(AW'(16 + off), 5'd0, 64'd1, dw[0], 5'd7, 1'b0, "R6 misalign add");
                    run_op(AW'(16 + off), 5'd4, 64'd1, dw[0], 5'd7, 1'b0, "R6 misalign illegal");
                    run_op(AW'(16 + off), 5'd9, 64'd1, dw[0], 5'd7, 1'b0, "R6 misalign unknown");
                end

        // R3 wrap in both widths; R7 neighbour word untouched
        put_dw(AW'(8), 64'hFFFF_FFFF_FFFF_FFFF);
        run_op(AW'(8), 5'd0, 64'd1, 1'b1, 5'd3, 1'b0, "R3 dword wrap");
        put_dw(AW'(24), 64'h7777_7777_FFFF_FFFF);
        run_op(AW'(24), 5'd0, 64'hFFFF_FFFF_0000_0001, 1'b0, 5'd4, 1'b0, "R3 R7 word wrap");
        put_dw(AW'(32), 64'h0123_4567_89AB_CDEF);
        run_op(AW'(36), 5'd8, 64'hDEAD_BEEF_CAFE_F00D, 1'b0, 5'd5, 1'b0, "R7 upper word swap");

        // R1 request while busy is ignored
        put_dw(AW'(56), 64'h5555_AAAA_5555_AAAA);
        run_op(AW'(40), 5'd1, 64'h0F0F_0F0F_0F0F_0F0F, 1'b1, 5'd31, 1'b1, "R1 busy");

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule